// File: doc/BRIEF.md
# Flash Controller Event Interrupt and DMA Request Router

This block sits beside the command and data engine of a NAND flash controller. It gathers that engine's event pulses and turns them into interrupt lines for the processor and request lines for a DMA engine. It keeps a sticky flag for each of six events: status error, ready/busy timeout, ECC error, transfer end, data FIFO request and control-code FIFO request. It also records overrun and underrun conditions for both FIFOs. Software sets the per-event enable masks, selects the access mode and clears flags through a small register write port.

The three error events are merged onto one shared error interrupt. Transfer end and the two FIFO requests each drive an interrupt line of their own. A 3-bit pending code names the highest-priority enabled event that is waiting. The FIFO request flags also drive two DMA request lines. The control-code line is held low while command access mode is selected. Every output is registered, so it follows the flag and mask state with one cycle of latency.

Top module: `nfc_evt_router`

## Requirements
- R1: While `rstN` is low and in the first cycle after it is released, every flag, `errIrq`, `endIrq`, `fifo0Irq`, `fifo1Irq`, `dmaDataReq`, `dmaCodeReq` and `pendId` read zero. Reset also clears all enables and the mode bits.
- R2: A one-cycle pulse on `evtPulse[i]` sets `evtFlags[i]` at the next clock edge, whatever the state of the enables. The flag stays set until it is cleared. The bit order is: 0 status error, 1 ready/busy timeout, 2 ECC error, 3 transfer end, 4 data FIFO request, 5 control-code FIFO request.
- R3: A write to address 1 clears each flag whose `wrData` bit is one. Bits 5:0 map to `evtFlags[5:0]`, bits 7:6 to the overruns of FIFO0 and FIFO1, and bits 9:8 to the underruns of FIFO0 and FIFO1. When a set pulse and a clear reach the same flag in the same cycle, the flag ends up set.
- R4: A write to address 0 loads the six interrupt enables from `wrData[5:0]`, in the same bit order as R2. Writes to address 3 change nothing. If a flag was set while its enable was off, turning the enable on raises the matching interrupt one cycle after the write takes effect.
- R5: `errIrq` is high exactly when, in the previous cycle, at least one of flags 0, 1 and 2 was set together with its enable.
- R6: `endIrq`, `fifo0Irq` and `fifo1Irq` are high exactly when, in the previous cycle, flag 3, 4 or 5 respectively was set together with its enable.
- R7: `pendId` gives the lowest-numbered flag i that, in the previous cycle, was set and enabled, encoded as i+1. It reads 0 when no such flag exists, and in that case every interrupt output is low.
- R8: A pulse on `ovrPulse[f]` sets `fifoErrFlags[f]` and a pulse on `udrPulse[f]` sets `fifoErrFlags[2+f]`. These flags are sticky, are cleared as described in R3, and never change any interrupt output or `pendId`.
- R9: A write to address 2 loads the configuration: bit 0 selects command access mode (1) or sector access mode (0), bit 1 enables data DMA and bit 2 enables control-code DMA. `dmaDataReq` is high exactly when, in the previous cycle, flag 4 and the data DMA enable were both set. The access mode does not affect it.
- R10: `dmaCodeReq` is high exactly when, in the previous cycle, flag 5 and the control-code DMA enable were both set and sector access mode was selected. In command access mode it stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| evtPulse | input | 6 | One-cycle event pulses, bit order as in R2 |
| ovrPulse | input | 2 | FIFO overrun pulses, FIFO0 in bit 0 |
| udrPulse | input | 2 | FIFO underrun pulses, FIFO0 in bit 0 |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Register address: 0 enables, 1 clear, 2 configuration |
| wrData | input | 16 | Register write data |
| evtFlags | output | 6 | Sticky event flags |
| fifoErrFlags | output | 4 | Sticky overrun (1:0) and underrun (3:2) flags |
| errIrq | output | 1 | Shared error interrupt |
| endIrq | output | 1 | Transfer end interrupt |
| fifo0Irq | output | 1 | Data FIFO request interrupt |
| fifo1Irq | output | 1 | Control-code FIFO request interrupt |
| pendId | output | 3 | Highest-priority enabled pending event, 0 when none |
| dmaDataReq | output | 1 | DMA request for the data FIFO |
| dmaCodeReq | output | 1 | DMA request for the control-code FIFO |

## Verification
The assertions assume only that the event pulses and register writes are ordinary synchronous inputs. Any pattern is legal, including a pulse and a clear of the same flag in one cycle and back-to-back writes to any address. They do not assume that pulses are sparse. The random stimulus therefore hits set/clear collisions, mode changes while a control-code request is pending, and writes to the unused address. Directed sequences add a flag set while its enable is off and then enabled, a collision on a single flag, and all six events pending at once.

// File: rtl/nfc_evt_pkg.sv
package nfc_evt_pkg;

  localparam int NUM_EVT   = 6;
  localparam int NUM_FIFO  = 2;
  localparam int NUM_ERR   = 3;
  localparam int ID_W      = 3;
  localparam int CFG_W     = 3;
  localparam int ADDR_W    = 2;
  localparam int REG_W     = 16;
  localparam int FERR_W    = 2 * NUM_FIFO;

  localparam logic [ADDR_W-1:0] ADDR_ENABLE = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_CLEAR  = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_CONFIG = 2'd2;

  localparam int CFG_CMD_MODE = 0;
  localparam int CFG_DATA_DMA = 1;
  localparam int CFG_CODE_DMA = 2;

  localparam int EVT_TEND  = 3;
  localparam int EVT_FIFO0 = 4;
  localparam int EVT_FIFO1 = 5;

  typedef enum logic [ID_W-1:0] {
    PEND_NONE   = 3'd0,
    PEND_STATUS = 3'd1,
    PEND_RBTO   = 3'd2,
    PEND_ECC    = 3'd3,
    PEND_TEND   = 3'd4,
    PEND_FIFO0  = 3'd5,
    PEND_FIFO1  = 3'd6
  } pendId_e;

  typedef struct packed {
    logic               enWr;
    logic               cfgWr;
    logic [NUM_EVT-1:0] evtClr;
    logic [FERR_W-1:0]  errClr;
    logic [NUM_EVT-1:0] enVal;
    logic [CFG_W-1:0]   cfgVal;
  } ctlStrobe_t;

endpackage

// File: rtl/nfc_evt_ctrl.sv
module nfc_evt_ctrl
  import nfc_evt_pkg::*;
(
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [REG_W-1:0]  wrData,
  output ctlStrobe_t        strobe
);

  logic hitEnable;
  logic hitClear;
  logic hitConfig;

  always_comb begin
    hitEnable = wrEn && (wrAddr == ADDR_ENABLE);
    hitClear  = wrEn && (wrAddr == ADDR_CLEAR);
    hitConfig = wrEn && (wrAddr == ADDR_CONFIG);
  end

  always_comb begin
    strobe        = '0;
    strobe.enWr   = hitEnable;
    strobe.cfgWr  = hitConfig;
    strobe.enVal  = wrData[NUM_EVT-1:0];
    strobe.cfgVal = wrData[CFG_W-1:0];
    if (hitClear) begin
      strobe.evtClr = wrData[NUM_EVT-1:0];
      strobe.errClr = wrData[NUM_EVT +: FERR_W];
    end
  end

endmodule

// File: rtl/nfc_evt_datapath.sv
module nfc_evt_datapath
  import nfc_evt_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  ctlStrobe_t         strobe,
  input  logic [NUM_EVT-1:0] evtPulse,
  input  logic [NUM_FIFO-1:0] ovrPulse,
  input  logic [NUM_FIFO-1:0] udrPulse,
  output logic [NUM_EVT-1:0] evtFlags,
  output logic [FERR_W-1:0]  fifoErrFlags,
  output logic [NUM_EVT-1:0] enableVec,
  output logic [CFG_W-1:0]   cfgVec,
  output logic               errIrq,
  output logic               endIrq,
  output logic               fifo0Irq,
  output logic               fifo1Irq,
  output logic [ID_W-1:0]    pendId,
  output logic               dmaDataReq,
  output logic               dmaCodeReq
);

  logic [FERR_W-1:0]  errSet;
  logic [NUM_EVT-1:0] active;
  pendId_e            pendNext;

  assign errSet = {udrPulse, ovrPulse};

  // sticky event flags, set dominates clear
  for (genvar i = 0; i < NUM_EVT; i++) begin : g_evt
    always_ff @(posedge clk) begin
      if (!rstN)                    evtFlags[i] <= 1'b0;
      else if (evtPulse[i])         evtFlags[i] <= 1'b1;
      else if (strobe.evtClr[i])    evtFlags[i] <= 1'b0;
    end
  end

  for (genvar j = 0; j < FERR_W; j++) begin : g_ferr
    always_ff @(posedge clk) begin
      if (!rstN)                    fifoErrFlags[j] <= 1'b0;
      else if (errSet[j])           fifoErrFlags[j] <= 1'b1;
      else if (strobe.errClr[j])    fifoErrFlags[j] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enableVec <= '0;
      cfgVec    <= '0;
    end else begin
      if (strobe.enWr)  enableVec <= strobe.enVal;
      if (strobe.cfgWr) cfgVec    <= strobe.cfgVal;
    end
  end

  assign active = evtFlags & enableVec;

  always_comb begin
    pendNext = PEND_NONE;
    for (int k = NUM_EVT - 1; k >= 0; k--) begin
      if (active[k]) pendNext = pendId_e'(ID_W'(k + 1));
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      errIrq     <= 1'b0;
      endIrq     <= 1'b0;
      fifo0Irq   <= 1'b0;
      fifo1Irq   <= 1'b0;
      pendId     <= '0;
      dmaDataReq <= 1'b0;
      dmaCodeReq <= 1'b0;
    end else begin
      errIrq     <= |active[NUM_ERR-1:0];
      endIrq     <= active[EVT_TEND];
      fifo0Irq   <= active[EVT_FIFO0];
      fifo1Irq   <= active[EVT_FIFO1];
      pendId     <= pendNext;
      dmaDataReq <= evtFlags[EVT_FIFO0] && cfgVec[CFG_DATA_DMA];
      dmaCodeReq <= evtFlags[EVT_FIFO1] && cfgVec[CFG_CODE_DMA]
                    && !cfgVec[CFG_CMD_MODE];
    end
  end

endmodule

// File: rtl/nfc_evt_router.sv
module nfc_evt_router
  import nfc_evt_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [5:0]  evtPulse,
  input  logic [1:0]  ovrPulse,
  input  logic [1:0]  udrPulse,
  input  logic        wrEn,
  input  logic [1:0]  wrAddr,
  input  logic [15:0] wrData,
  output logic [5:0]  evtFlags,
  output logic [3:0]  fifoErrFlags,
  output logic        errIrq,
  output logic        endIrq,
  output logic        fifo0Irq,
  output logic        fifo1Irq,
  output logic [2:0]  pendId,
  output logic        dmaDataReq,
  output logic        dmaCodeReq
);

  ctlStrobe_t         strobe;
  logic [NUM_EVT-1:0] enableVec;
  logic [CFG_W-1:0]   cfgVec;

  nfc_evt_ctrl i_ctrl (
    .wrEn   (wrEn),
    .wrAddr (wrAddr),
    .wrData (wrData),
    .strobe (strobe)
  );

  nfc_evt_datapath i_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .evtPulse     (evtPulse),
    .ovrPulse     (ovrPulse),
    .udrPulse     (udrPulse),
    .evtFlags     (evtFlags),
    .fifoErrFlags (fifoErrFlags),
    .enableVec    (enableVec),
    .cfgVec       (cfgVec),
    .errIrq       (errIrq),
    .endIrq       (endIrq),
    .fifo0Irq     (fifo0Irq),
    .fifo1Irq     (fifo1Irq),
    .pendId       (pendId),
    .dmaDataReq   (dmaDataReq),
    .dmaCodeReq   (dmaCodeReq)
  );

endmodule

// File: rtl/nfc_evt_router_chk.sv
module nfc_evt_router_chk (
  input logic        clk,
  input logic        rstN,
  input logic [5:0]  evtPulse,
  input logic        wrEn,
  input logic [1:0]  wrAddr,
  input logic [15:0] wrData,
  input logic [5:0]  evtFlags,
  input logic [5:0]  enableVec,
  input logic [2:0]  cfgVec,
  input logic        errIrq,
  input logic        endIrq,
  input logic        fifo0Irq,
  input logic        fifo1Irq,
  input logic [2:0]  pendId,
  input logic        dmaCodeReq
);

  for (genvar i = 0; i < 6; i++) begin : g_flag
    AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
      (evtFlags[i] && !(wrEn && wrAddr == 2'd1 && wrData[i])) |=> evtFlags[i]); // R2
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rstN)
      evtPulse[i] |=> evtFlags[i]); // R3
    AST_FLAG_NEEDS_PULSE: assert property (@(posedge clk) disable iff (!rstN)
      $rose(evtFlags[i]) |-> $past(evtPulse[i])); // R2
  end

  AST_ERR_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    ((evtFlags[2:0] & enableVec[2:0]) == 3'b000) |=> !errIrq); // R5
  AST_PEND_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    pendId <= 3'd6); // R7
  AST_PEND_NONE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (pendId == 3'd0) |-> !(errIrq || endIrq || fifo0Irq || fifo1Irq)); // R7
  AST_CODE_DMA_CMD: assert property (@(posedge clk) disable iff (!rstN)
    cfgVec[0] |=> !dmaCodeReq); // R10

endmodule

bind nfc_evt_router nfc_evt_router_chk i_chk (
  .clk        (clk),
  .rstN       (rstN),
  .evtPulse   (evtPulse),
  .wrEn       (wrEn),
  .wrAddr     (wrAddr),
  .wrData     (wrData),
  .evtFlags   (evtFlags),
  .enableVec  (enableVec),
  .cfgVec     (cfgVec),
  .errIrq     (errIrq),
  .endIrq     (endIrq),
  .fifo0Irq   (fifo0Irq),
  .fifo1Irq   (fifo1Irq),
  .pendId     (pendId),
  .dmaCodeReq (dmaCodeReq)
);

// File: tb/test_nfc_evt_router.sv
module test_nfc_evt_router;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [5:0]  evtPulse = '0;
  logic [1:0]  ovrPulse = '0;
  logic [1:0]  udrPulse = '0;
  logic        wrEn = 1'b0;
  logic [1:0]  wrAddr = '0;
  logic [15:0] wrData = '0;
  logic [5:0]  evtFlags;
  logic [3:0]  fifoErrFlags;
  logic        errIrq, endIrq, fifo0Irq, fifo1Irq;
  logic [2:0]  pendId;
  logic        dmaDataReq, dmaCodeReq;

  int testCount = 0;
  int failCount = 0;

  logic [5:0] mFlag = '0;
  logic [3:0] mErr  = '0;
  logic [5:0] mEn   = '0;
  logic [2:0] mCfg  = '0;

  logic       xErr, xEnd, xF0, xF1, xDd, xDc;
  logic [2:0] xPend;

  always #10 clk = ~clk;

  nfc_evt_router i_nfc_evt_router (
    .clk(clk), .rstN(rstN), .evtPulse(evtPulse), .ovrPulse(ovrPulse),
    .udrPulse(udrPulse), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .evtFlags(evtFlags), .fifoErrFlags(fifoErrFlags), .errIrq(errIrq),
    .endIrq(endIrq), .fifo0Irq(fifo0Irq), .fifo1Irq(fifo1Irq),
    .pendId(pendId), .dmaDataReq(dmaDataReq), .dmaCodeReq(dmaCodeReq)
  );

  function automatic logic [2:0] expPend(input logic [5:0] act);
    for (int k = 0; k < 6; k++) if (act[k]) return 3'(k + 1);
    return 3'd0;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    testCount++;
    if (act != exp) begin
      failCount++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // one clock: drive at negedge, model at edge, compare at next negedge
  task automatic step(input logic [5:0] ev, input logic [1:0] ov, input logic [1:0] ud,
                      input logic we, input logic [1:0] wa, input logic [15:0] wd);
    logic [5:0] act;
    evtPulse = ev; ovrPulse = ov; udrPulse = ud;
    wrEn = we; wrAddr = wa; wrData = wd;
    @(posedge clk);
    act   = mFlag & mEn;
    xErr  = |act[2:0];
    xEnd  = act[3];
    xF0   = act[4];
    xF1   = act[5];
    xPend = expPend(act);
    xDd   = mFlag[4] & mCfg[1];
    xDc   = mFlag[5] & mCfg[2] & ~mCfg[0];
    if (we && wa == 2'd1) begin
      mFlag = mFlag & ~wd[5:0];
      mErr  = mErr & ~wd[9:6];
    end
    mFlag = mFlag | ev;
    mErr  = mErr | {ud, ov};
    if (we && wa == 2'd0) mEn  = wd[5:0];
    if (we && wa == 2'd2) mCfg = wd[2:0];
    @(negedge clk);
    check("R2 evtFlags",     int'(evtFlags),     int'(mFlag));
    check("R8 fifoErrFlags", int'(fifoErrFlags), int'(mErr));
    check("R5 errIrq",       int'(errIrq),       int'(xErr));
    check("R6 endIrq",       int'(endIrq),       int'(xEnd));
    check("R6 fifo0Irq",     int'(fifo0Irq),     int'(xF0));
    check("R6 fifo1Irq",     int'(fifo1Irq),     int'(xF1));
    check("R7 pendId",       int'(pendId),       int'(xPend));
    check("R9 dmaDataReq",   int'(dmaDataReq),   int'(xDd));
    check("R10 dmaCodeReq",  int'(dmaCodeReq),   int'(xDc));
  endtask

  task automatic idle();
    step('0, '0, '0, 1'b0, 2'd0, 16'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failCount++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    evtPulse = 6'h3f;
    @(negedge clk);
    check("R1 flags in reset", int'({evtFlags, fifoErrFlags}), 0);
    check("R1 outputs in reset",
          int'({errIrq, endIrq, fifo0Irq, fifo1Irq, pendId, dmaDataReq, dmaCodeReq}), 0);
    evtPulse = '0;
    rstN = 1'b1;
    @(negedge clk);
    check("R1 first cycle after reset",
          int'({evtFlags, errIrq, endIrq, fifo0Irq, fifo1Irq, pendId, dmaDataReq, dmaCodeReq}), 0);

    // R4: flag set while disabled, enable later raises irq
    step(6'b000100, '0, '0, 1'b0, 2'd0, 16'h0);
    idle();
    check("R4 masked flag gives no irq", int'(errIrq), 0);
    step('0, '0, '0, 1'b1, 2'd0, 16'h0004);
    idle();
    check("R4 enable after flag raises errIrq", int'(errIrq), 1);

    // R3: set and clear on the same flag in one cycle
    step(6'b000100, '0, '0, 1'b1, 2'd1, 16'h0004);
    check("R3 set wins over clear", int'(evtFlags[2]), 1);
    step('0, '0, '0, 1'b1, 2'd1, 16'h03ff);
    check("R3 clear all", int'(evtFlags), 0);

    // R7: all pending, then peel from the top
    step('0, '0, '0, 1'b1, 2'd0, 16'h003f);
    step(6'h3f, 2'b11, 2'b11, 1'b0, 2'd0, 16'h0);
    idle();
    check("R7 all pending reports status", int'(pendId), 1);
    step('0, '0, '0, 1'b1, 2'd1, 16'h0007);
    idle();
    check("R7 after errors cleared", int'(pendId), 4);
    // R8: fifo error flags leave irqs alone
    step('0, '0, '0, 1'b1, 2'd1, 16'h0038);
    idle();
    check("R8 fifo errors do not interrupt",
          int'({errIrq, endIrq, fifo0Irq, fifo1Irq, pendId}), 0);
    step('0, '0, '0, 1'b1, 2'd1, 16'h03c0);

    // R10: command mode blocks code DMA; R9 data DMA unaffected
    step(6'b110000, '0, '0, 1'b1, 2'd2, 16'h0007);
    idle();
    check("R10 command mode blocks code DMA", int'(dmaCodeReq), 0);
    check("R9 data DMA in command mode", int'(dmaDataReq), 1);
    step('0, '0, '0, 1'b1, 2'd2, 16'h0006);
    idle();
    check("R10 sector mode allows code DMA", int'(dmaCodeReq), 1);
    step('0, '0, '0, 1'b1, 2'd3, 16'hffff);
    check("R4 address 3 write ignored", int'(evtFlags), int'(mFlag));

    for (int n = 0; n < 4000; n++) begin
      logic [5:0]  ev;
      logic [1:0]  ov, ud;
      logic        we;
      ev = '0; ov = '0; ud = '0;
      for (int b = 0; b < 6; b++) ev[b] = ($urandom % 8) == 0;
      for (int b = 0; b < 2; b++) begin
        ov[b] = ($urandom % 16) == 0;
        ud[b] = ($urandom % 16) == 0;
      end
      we = ($urandom % 4) == 0;
      step(ev, ov, ud, we, 2'($urandom), 16'($urandom));
    end

    $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

endmodule